// File: doc/BRIEF.md
# Configurable Distributed Lookup-Table RAM

This block is a tiny bit-wide memory built from two identical 16-entry, 1-bit storage cells. A parameter picks how the cells are arranged: one 16x1 RAM, a pair of independent 16x1 RAMs, one 32x1 RAM, or a 16x1 RAM with an extra read-only port. Writes are edge-triggered on a write clock whose active edge is chosen per instance. Reads are purely combinational from whatever address sits on the read inputs.

The block carries no stream of transactions, so there is no valid/ready pair. Every pin is a plain control or data level. A write is simply an enable that is high at the active clock edge. A read is an address held steady long enough for the output to settle. No back-pressure exists, because the memory accepts one write on every active edge. Power-up contents come from an initial-value parameter. No reset is provided.

Top module: `cfg_lutram`

## Requirements
- R1: When `we` is high at the active edge of `wclk`, the value of `din_a` at that edge is stored at the address captured at that edge, and it can then be read back on `spo_a`.
- R2: When `we` is low at an active edge, no location in any mode changes, whatever the data and address pins carry.
- R3: `NEG_EDGE`=0 (the default) makes the rising edge of `wclk` active and `NEG_EDGE`=1 makes the falling edge active. No write happens at the other edge.
- R4: `spo_a`, `spo_b` and `dpo` follow their address inputs combinationally, with no clock edge needed.
- R5: After a write to the location currently on the address pins, the output shows the new bit with no further clock edge.
- R6: In mode `LR_SP16` (16 locations at `addr_a`), `spo_b` and `dpo` stay 0, and `addr_b`, `din_b`, `dp_addr` and `addr_hi` have no effect.
- R7: In mode `LR_PAIR16` there are two independent RAMs that share `we` and `wclk`. RAM A uses `addr_a`/`din_a`/`spo_a`, and RAM B uses `addr_b`/`din_b`/`spo_b`.
- R8: In mode `LR_SP32` the location index is `{addr_hi, addr_a}`. `addr_hi` therefore selects the 16-entry half that is both written and read.
- R9: In mode `LR_DP16`, `addr_a` writes and reads through `spo_a`. `dpo` independently reads the same contents at `dp_addr`.
- R10: In mode `LR_DP16`, if `dp_addr` equals the address being written, `dpo` shows the old bit before the active edge and the new bit after it.
- R11: At power-up, location i of the single 16x1 RAM, RAM A, the dual-port RAM and the 32x1 RAM holds bit i of `INIT`. Location i of RAM B holds bit 16+i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock; active edge set by `NEG_EDGE` |
| we | input | 1 | Write enable, active high |
| addr_a | input | 4 | Read/write address of the primary port |
| addr_hi | input | 1 | Half select in 32x1 mode |
| addr_b | input | 4 | Address of RAM B in pair mode |
| din_a | input | 1 | Write data of the primary port |
| din_b | input | 1 | Write data of RAM B in pair mode |
| dp_addr | input | 4 | Read-only address in dual-port mode |
| spo_a | output | 1 | Primary read data |
| spo_b | output | 1 | RAM B read data in pair mode, else 0 |
| dpo | output | 1 | Read-only port data in dual-port mode, else 0 |

## Verification
The bench goes after a same-address write seen through the read-only port while the clock sits between its two edges. A design that writes on the wrong edge, or that registers its read, would show the new bit too early or too late there. It sweeps the 32-deep arrangement across both halves. A wrong half select would either corrupt the other half or return the other half's bit. It also holds data against a low enable, and drives the unused pins in the single 16x1 arrangement to show that they leak nothing.

// File: rtl/lutram_pkg.sv
package lutram_pkg;
  typedef enum logic [1:0] {
    LR_SP16   = 2'd0,
    LR_PAIR16 = 2'd1,
    LR_SP32   = 2'd2,
    LR_DP16   = 2'd3
  } lr_mode_e;

  localparam int unsigned LR_CELLS = 2;
endpackage

// File: rtl/lutram_cell.sv
module lutram_cell #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW = $clog2(DEPTH),
  parameter logic [DEPTH-1:0] INIT = '0,
  parameter bit NEG_EDGE = 1'b0
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic          wd,
  input  logic [AW-1:0] ra,
  output logic          rd
);
  logic [DEPTH-1:0] bits = INIT;

  // active edge picked per instance; only one branch exists after elaboration
  generate
    if (NEG_EDGE) begin : g_fall
      always_ff @(negedge wclk) begin
        if (we) bits[wa] <= wd;
      end
    end else begin : g_rise
      always_ff @(posedge wclk) begin
        if (we) bits[wa] <= wd;
      end
    end
  endgenerate

  assign rd = bits[ra];
endmodule

// File: rtl/lutram_route.sv
module lutram_route
  import lutram_pkg::*;
#(
  parameter lr_mode_e MODE = LR_SP16,
  parameter int unsigned AW = 4
) (
  input  logic                       we,
  input  logic [AW-1:0]              addr_a,
  input  logic                       addr_hi,
  input  logic [AW-1:0]              addr_b,
  input  logic                       din_a,
  input  logic                       din_b,
  input  logic [AW-1:0]              dp_addr,
  input  logic [LR_CELLS-1:0]        cell_rd,
  output logic [LR_CELLS-1:0]        cell_we,
  output logic [LR_CELLS-1:0][AW-1:0] cell_wa,
  output logic [LR_CELLS-1:0]        cell_wd,
  output logic [LR_CELLS-1:0][AW-1:0] cell_ra,
  output logic                       spo_a,
  output logic                       spo_b,
  output logic                       dpo
);
  always_comb begin
    cell_we    = '0;
    cell_wa    = '0;
    cell_wd    = '0;
    cell_ra    = '0;
    cell_we[0] = we;
    cell_wa[0] = addr_a;
    cell_wd[0] = din_a;
    cell_ra[0] = addr_a;
    spo_a      = cell_rd[0];
    spo_b      = 1'b0;
    dpo        = 1'b0;
    case (MODE)
      LR_PAIR16: begin
        cell_we[1] = we;
        cell_wa[1] = addr_b;
        cell_wd[1] = din_b;
        cell_ra[1] = addr_b;
        spo_b      = cell_rd[1];
      end
      LR_SP32: begin
        // top index bit steers both the write strobe and the read mux
        cell_we[0] = we & ~addr_hi;
        cell_we[1] = we & addr_hi;
        cell_wa[1] = addr_a;
        cell_wd[1] = din_a;
        cell_ra[1] = addr_a;
        spo_a      = addr_hi ? cell_rd[1] : cell_rd[0];
      end
      LR_DP16: begin
        // both cells hold the same bits; cell 1 serves the read-only port
        cell_we[1] = we;
        cell_wa[1] = addr_a;
        cell_wd[1] = din_a;
        cell_ra[1] = dp_addr;
        dpo        = cell_rd[1];
      end
      default: begin
      end
    endcase
  end
endmodule

// File: rtl/cfg_lutram.sv
module cfg_lutram
  import lutram_pkg::*;
#(
  parameter lr_mode_e MODE = LR_SP16,
  parameter bit NEG_EDGE = 1'b0,
  parameter int unsigned DEPTH = 16,
  parameter logic [LR_CELLS*DEPTH-1:0] INIT = '0
) (
  input  logic                     wclk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr_a,
  input  logic                     addr_hi,
  input  logic [$clog2(DEPTH)-1:0] addr_b,
  input  logic                     din_a,
  input  logic                     din_b,
  input  logic [$clog2(DEPTH)-1:0] dp_addr,
  output logic                     spo_a,
  output logic                     spo_b,
  output logic                     dpo
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [LR_CELLS-1:0]         cell_we;
  logic [LR_CELLS-1:0][AW-1:0] cell_wa;
  logic [LR_CELLS-1:0]         cell_wd;
  logic [LR_CELLS-1:0][AW-1:0] cell_ra;
  logic [LR_CELLS-1:0]         cell_rd;

  lutram_route #(.MODE(MODE), .AW(AW)) u_route (
    .we(we), .addr_a(addr_a), .addr_hi(addr_hi), .addr_b(addr_b),
    .din_a(din_a), .din_b(din_b), .dp_addr(dp_addr), .cell_rd(cell_rd),
    .cell_we(cell_we), .cell_wa(cell_wa), .cell_wd(cell_wd), .cell_ra(cell_ra),
    .spo_a(spo_a), .spo_b(spo_b), .dpo(dpo)
  );

  generate
    for (genvar k = 0; k < LR_CELLS; k++) begin : g_cell
      // in dual-port mode the shadow cell must start as a copy of cell 0
      localparam logic [DEPTH-1:0] CELL_INIT =
        (MODE == LR_DP16) ? INIT[DEPTH-1:0] : INIT[k*DEPTH +: DEPTH];
      lutram_cell #(.DEPTH(DEPTH), .AW(AW), .INIT(CELL_INIT), .NEG_EDGE(NEG_EDGE)) u_cell (
        .wclk(wclk), .we(cell_we[k]), .wa(cell_wa[k]), .wd(cell_wd[k]),
        .ra(cell_ra[k]), .rd(cell_rd[k])
      );
    end
  endgenerate
endmodule

// File: rtl/lutram_chk.sv
module lutram_chk
  import lutram_pkg::*;
#(
  parameter lr_mode_e MODE = LR_SP16,
  parameter bit NEG_EDGE = 1'b0,
  parameter int unsigned AW = 4
) (
  input logic          wclk,
  input logic          we,
  input logic [AW-1:0] addr_a,
  input logic          addr_hi,
  input logic [AW-1:0] addr_b,
  input logic          din_a,
  input logic          din_b,
  input logic [AW-1:0] dp_addr,
  input logic          spo_a,
  input logic          spo_b,
  input logic          dpo
);
  logic aclk;
  logic armed = 1'b0;
  assign aclk = NEG_EDGE ? ~wclk : wclk;
  always_ff @(posedge aclk) armed <= 1'b1;

  p_write_lands_r1: assert property (@(posedge aclk) disable iff (!armed)
    we |=> (($stable(addr_a) && $stable(addr_hi)) -> (spo_a == $past(din_a))));

  p_hold_when_idle_r2: assert property (@(posedge aclk) disable iff (!armed)
    !we |=> (($stable(addr_a) && $stable(addr_hi)) -> $stable(spo_a)));

  p_pair_b_write_r7: assert property (@(posedge aclk) disable iff (!armed)
    (MODE == LR_PAIR16 && we) |=> ($stable(addr_b) -> (spo_b == $past(din_b))));

  p_ports_agree_r9: assert property (@(posedge aclk) disable iff (!armed)
    (MODE == LR_DP16 && dp_addr == addr_a) |-> (dpo == spo_a));

  p_same_addr_new_r10: assert property (@(posedge aclk) disable iff (!armed)
    (MODE == LR_DP16 && we && dp_addr == addr_a)
      |=> (($stable(dp_addr) && $stable(addr_a)) -> (dpo == $past(din_a))));
endmodule

bind cfg_lutram lutram_chk #(.MODE(MODE), .NEG_EDGE(NEG_EDGE), .AW($clog2(DEPTH))) u_chk (
  .wclk(wclk), .we(we), .addr_a(addr_a), .addr_hi(addr_hi), .addr_b(addr_b),
  .din_a(din_a), .din_b(din_b), .dp_addr(dp_addr),
  .spo_a(spo_a), .spo_b(spo_b), .dpo(dpo)
);

// File: tb/sim_cfg_lutram.sv
`timescale 1ns/1ps
module sim_cfg_lutram;
  import lutram_pkg::*;
  localparam logic [31:0] IV = 32'h96C3_5AE1;

  logic wclk = 1'b0;
  logic we = 1'b0, hi = 1'b0, da = 1'b0, db = 1'b0;
  logic [3:0] aa = '0, ab = '0, dpa = '0;
  logic s0a, s0b, d0, s1a, s1b, d1, s2a, s2b, d2, s3a, s3b, d3, s4a, s4b, d4;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [15:0] m0, p0, p1, mdp;
  logic [31:0] m32;

  always #2 wclk = ~wclk;

  cfg_lutram #(.MODE(LR_SP16), .NEG_EDGE(1'b0), .INIT(IV)) u0 (.wclk(wclk), .we(we), .addr_a(aa),
    .addr_hi(hi), .addr_b(ab), .din_a(da), .din_b(db), .dp_addr(dpa), .spo_a(s0a), .spo_b(s0b), .dpo(d0));
  cfg_lutram #(.MODE(LR_PAIR16), .NEG_EDGE(1'b0), .INIT(IV)) u1 (.wclk(wclk), .we(we), .addr_a(aa),
    .addr_hi(hi), .addr_b(ab), .din_a(da), .din_b(db), .dp_addr(dpa), .spo_a(s1a), .spo_b(s1b), .dpo(d1));
  cfg_lutram #(.MODE(LR_SP32), .NEG_EDGE(1'b1), .INIT(IV)) u2 (.wclk(wclk), .we(we), .addr_a(aa),
    .addr_hi(hi), .addr_b(ab), .din_a(da), .din_b(db), .dp_addr(dpa), .spo_a(s2a), .spo_b(s2b), .dpo(d2));
  cfg_lutram #(.MODE(LR_DP16), .NEG_EDGE(1'b0), .INIT(IV)) u3 (.wclk(wclk), .we(we), .addr_a(aa),
    .addr_hi(hi), .addr_b(ab), .din_a(da), .din_b(db), .dp_addr(dpa), .spo_a(s3a), .spo_b(s3b), .dpo(d3));
  cfg_lutram #(.MODE(LR_DP16), .NEG_EDGE(1'b1), .INIT(IV)) u4 (.wclk(wclk), .we(we), .addr_a(aa),
    .addr_hi(hi), .addr_b(ab), .din_a(da), .din_b(db), .dp_addr(dpa), .spo_a(s4a), .spo_b(s4b), .dpo(d4));

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string ph);
    chk({ph, " R6 u0 spo_a"}, s0a, m0[aa]);
    chk({ph, " R6 u0 spo_b zero"}, s0b, 1'b0);
    chk({ph, " R6 u0 dpo zero"}, d0, 1'b0);
    chk({ph, " R7 u1 spo_a"}, s1a, p0[aa]);
    chk({ph, " R7 u1 spo_b"}, s1b, p1[ab]);
    chk({ph, " R8 u2 spo_a"}, s2a, m32[{hi, aa}]);
    chk({ph, " R9 u3 spo_a"}, s3a, mdp[aa]);
    chk({ph, " R9 u3 dpo"}, d3, mdp[dpa]);
    chk({ph, " R9 u4 spo_a"}, s4a, mdp[aa]);
    chk({ph, " R9 u4 dpo"}, d4, mdp[dpa]);
  endtask

  function automatic void model_write();
    if (we) begin
      m0[aa] = da; p0[aa] = da; p1[ab] = db; m32[{hi, aa}] = da; mdp[aa] = da;
    end
  endfunction

  // called at posedge+1: inputs already driven; settles, then crosses both edges
  task automatic step(string ph);
    #0.5 check_all({ph, " R4 pre-edge"});
    @(posedge wclk); #1;
    model_write();
    check_all({ph, " R1 R5 post-edge"});
  endtask

  initial begin
    void'($urandom(32'h0001_d5e7));
    m0 = IV[15:0]; p0 = IV[15:0]; p1 = IV[31:16]; mdp = IV[15:0]; m32 = IV;
    #1;
    // R11: power-up contents, swept combinationally (R4)
    for (int i = 0; i < 32; i++) begin
      aa = i[3:0]; hi = i[4]; ab = i[3:0]; dpa = 4'(15 - (i % 16));
      #0.5 check_all("R11 init");
    end
    @(posedge wclk); #1;

    // R3 and R10: same-address write, observed between the two edges
    we = 1'b1; aa = 4'd5; dpa = 4'd5; hi = 1'b0; ab = 4'd9;
    da = ~mdp[5]; db = ~p1[9];
    @(negedge wclk); #0.5;
    chk("R3 R10 u4 falling dpo new", d4, da);
    chk("R3 R10 u3 rising dpo old", d3, mdp[5]);
    chk("R3 u2 falling spo_a new", s2a, da);
    chk("R3 u0 rising spo_a old", s0a, m0[5]);
    @(posedge wclk); #1;
    model_write();
    check_all("R3 R10 after rising");

    // R2: enable low with data opposite to stored bits
    we = 1'b0; da = ~m0[aa]; db = ~p1[ab];
    step("R2 idle");
    hi = 1'b1; da = ~m32[{1'b1, aa}];
    step("R2 R8 idle upper");

    // R8: write upper half, then lower half of the same low index
    we = 1'b1; hi = 1'b1; aa = 4'd3; da = ~m32[19];
    step("R8 upper");
    hi = 1'b0; da = ~m32[3];
    step("R8 lower");
    we = 1'b0; hi = 1'b1;
    step("R8 readback");

    // R6: unused pins toggled in 16x1 mode have no effect
    we = 1'b0; ab = ~ab; db = ~db; dpa = ~dpa; hi = ~hi;
    step("R6 ignore");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      we  = ($urandom % 3) != 0;
      aa  = 4'($urandom);
      ab  = 4'($urandom);
      hi  = 1'($urandom);
      da  = 1'($urandom);
      db  = 1'($urandom);
      dpa = (($urandom % 4) == 0) ? aa : 4'($urandom);
      step("rand");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule